// File: doc/BRIEF.md
# Pin Interrupt Edge Filter

This block watches a port of external interrupt pins and turns a clean transition on any of them into a latched interrupt flag. Each pin first passes through a two-flop synchronizer. A small per-pin state counter then checks that the input has been at the inactive level for four samples in a row. After that it waits for four active samples in a row. Only when both runs have been seen does the pin's flag set, so short glitches and bouncing are rejected. A polarity bit chooses per pin whether the active level is low (falling edge) or high (rising edge).

In normal operation the filter takes a sample on every clock. When the stop-mode input is high, it samples only on cycles where the low-power strobe is high. Each pin raises a request for the low-power sampling clock only while that request is useful: the pin is enabled, its flag is clear, and its filter is still gathering the inactive run or has just armed. The block ORs the per-pin requests into a single clock-run output. It also ORs the enabled flags into a single interrupt request. Software clears a flag by writing 1 to its bit.

Top module: `pin_edge_filter`

## Requirements
- R1: While reset is held, every flag is 0 and the interrupt output is 0. The filter counts are cleared, so each pin whose enable is 1 shows its low-power clock request high.
- R2: With polarity 0 (active low), a pin that has been high for at least four samples and then goes low for four samples sets its flag. Because of the two-flop synchronizer, the flag shows on the sixth rising clock edge after the input changes and not before.
- R3: With polarity 1 (active high), a pin that has been low for at least four samples and then goes high for four samples sets its flag on the sixth clock edge after the change.
- R4: An active run shorter than four samples does not set the flag. It also does not disarm the pin: a qualified inactive run stays armed until a full run of four active samples completes.
- R5: An inactive run shorter than four samples does not arm the pin. A following active run of any length leaves the flag at 0.
- R6: After a valid edge the pin needs a fresh run of four inactive samples. Staying at the active level, even after the flag is cleared, never sets the flag again.
- R7: When the clear strobe is high, each mask bit at 1 clears that pin's flag on the next clock edge. Mask bits at 0 leave the flags unchanged. If an edge completes in the same cycle as a clear, the set wins.
- R8: The interrupt output is high exactly when some pin has both its flag and its enable at 1. A flag whose enable is 0 does not raise the interrupt.
- R9: While the stop-mode input is high, the filter advances only on cycles where the low-power strobe is high. Without strobes no flag can be set, and the fourth strobed active sample sets the flag.
- R10: A pin's low-power clock request is high only when its filter count is at most four, its enable is 1 and its flag is 0. The count stands at four once the inactive run has armed and rises with each active sample. The clock-run output is the OR of all requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Raw asynchronous pin levels |
| polarity | input | NPINS | Per pin: 0 = active low, 1 = active high |
| irq_en | input | NPINS | Per-pin interrupt enable |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_mask | input | NPINS | Write-1-to-clear mask used with the strobe |
| stop_mode | input | 1 | 1 = sample only on lp_strobe |
| lp_strobe | input | 1 | Low-power oscillator sample tick |
| flag_o | output | NPINS | Per-pin edge flags |
| irq_o | output | 1 | Combined interrupt request |
| lp_clk_req_o | output | NPINS | Per-pin low-power clock request |
| lp_clk_run_o | output | 1 | Any pin needs the low-power clock |

## Verification
The bench checks the exact edge on which a flag appears, counted through the synchronizer. A design off by one register, or one that counts three samples instead of four, sets the flag a cycle early or late. It sends active runs of three samples and inactive runs of three samples. A filter that drops its armed state on a short active run, or arms on a short inactive run, then misses the real edge or fires on a false one. It holds a pin active after an edge to catch a design that re-fires without a fresh inactive run. It withholds strobes in stop mode to catch a design that still samples on the system clock. It also watches the low-power request drop on the first active sample to catch a request that ignores the count.

// File: rtl/pef_pkg.sv
package pef_pkg;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_STOP = 1'b1
    } pef_mode_e;

    // A synchronized level is active when it matches the polarity bit.
    function automatic logic level_is_active(input logic lvl, input logic pol);
        return lvl == pol;
    endfunction

endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] stage_d;
    logic [STAGES-1:0][W-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= rst_val;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pef_pin_filter.sv
module pef_pin_filter #(
    parameter int RUN_LEN = 4,
    parameter int CW      = $clog2(2 * RUN_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_en,
    input  logic          level_in,
    input  logic          polarity,
    input  logic          irq_en,
    input  logic          clr,
    output logic          flag,
    output logic          lp_req,
    output logic [CW-1:0] cnt_o
);
    import pef_pkg::*;

    localparam logic [CW-1:0] ARMED = CW'(RUN_LEN);
    localparam logic [CW-1:0] LAST  = CW'(2 * RUN_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } filt_t;

    filt_t st_d, st_q;
    logic  active;
    logic  edge_hit;

    always_comb begin
        active   = level_is_active(level_in, polarity);
        st_d     = st_q;
        edge_hit = 1'b0;
        if (sample_en) begin
            if (st_q.cnt < ARMED) begin
                // gathering the inactive run
                st_d.cnt = active ? '0 : st_q.cnt + 1'b1;
            end else if (active) begin
                if (st_q.cnt == LAST) begin
                    st_d.cnt = '0;
                    edge_hit = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                // stay armed, active run restarts
                st_d.cnt = ARMED;
            end
        end
        if (clr)      st_d.flag = 1'b0;
        if (edge_hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag   = st_q.flag;
    assign cnt_o  = st_q.cnt;
    assign lp_req = (st_q.cnt <= ARMED) && irq_en && !st_q.flag;

endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
    parameter int NPINS       = 8,
    parameter int RUN_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] polarity,
    input  logic [NPINS-1:0] irq_en,
    input  logic             flag_clr_we,
    input  logic [NPINS-1:0] flag_clr_mask,
    input  logic             stop_mode,
    input  logic             lp_strobe,
    output logic [NPINS-1:0] flag_o,
    output logic             irq_o,
    output logic [NPINS-1:0] lp_clk_req_o,
    output logic             lp_clk_run_o
);
    import pef_pkg::*;

    localparam int CW = $clog2(2 * RUN_LEN);

    pef_mode_e                  mode;
    logic                       sample_en;
    logic [NPINS-1:0]           pin_sync;
    logic [NPINS-1:0]           clr_vec;
    logic [NPINS-1:0][CW-1:0]   cnt_all;

    always_comb begin
        mode      = stop_mode ? MODE_STOP : MODE_RUN;
        sample_en = (mode == MODE_STOP) ? lp_strobe : 1'b1;
        clr_vec   = flag_clr_we ? flag_clr_mask : '0;
    end

    pef_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .rst_val  ('0),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pef_pin_filter #(
            .RUN_LEN (RUN_LEN),
            .CW      (CW)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (sample_en),
            .level_in  (pin_sync[i]),
            .polarity  (polarity[i]),
            .irq_en    (irq_en[i]),
            .clr       (clr_vec[i]),
            .flag      (flag_o[i]),
            .lp_req    (lp_clk_req_o[i]),
            .cnt_o     (cnt_all[i])
        );
    end

    assign irq_o        = |(flag_o & irq_en);
    assign lp_clk_run_o = |lp_clk_req_o;

endmodule

// File: rtl/pef_checker.sv
module pef_checker #(
    parameter int NPINS = 8,
    parameter int CW    = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stop_mode,
    input logic                     lp_strobe,
    input logic [NPINS-1:0]         irq_en,
    input logic [NPINS-1:0]         flag_o,
    input logic                     irq_o,
    input logic [NPINS-1:0]         lp_clk_req_o,
    input logic                     lp_clk_run_o,
    input logic [NPINS-1:0][CW-1:0] cnt_all
);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en != '0)); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o != '0)); // R8
    AST_STOP_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !lp_strobe) |=> $stable(cnt_all)); // R9
    AST_RUN_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_clk_req_o != '0) |-> lp_clk_run_o); // R10

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        AST_REQ_OFF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            flag_o[i] |-> !lp_clk_req_o[i]); // R10
        AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_o[i]) |-> (cnt_all[i] == '0)); // R6
    end

endmodule

bind pin_edge_filter pef_checker #(
    .NPINS (NPINS),
    .CW    (CW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_mode    (stop_mode),
    .lp_strobe    (lp_strobe),
    .irq_en       (irq_en),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .lp_clk_req_o (lp_clk_req_o),
    .lp_clk_run_o (lp_clk_run_o),
    .cnt_all      (cnt_all)
);

// File: tb/pin_edge_filter_tb.sv
module pin_edge_filter_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pin_in, polarity, irq_en, flag_clr_mask;
    logic         flag_clr_we, stop_mode, lp_strobe;
    logic [N-1:0] flag_o, lp_clk_req_o;
    logic         irq_o, lp_clk_run_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pin_edge_filter #(.NPINS(N)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .polarity      (polarity),
        .irq_en        (irq_en),
        .flag_clr_we   (flag_clr_we),
        .flag_clr_mask (flag_clr_mask),
        .stop_mode     (stop_mode),
        .lp_strobe     (lp_strobe),
        .flag_o        (flag_o),
        .irq_o         (irq_o),
        .lp_clk_req_o  (lp_clk_req_o),
        .lp_clk_run_o  (lp_clk_run_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [N-1:0] m);
        flag_clr_we   = 1'b1;
        flag_clr_mask = m;
        step(1);
        flag_clr_we   = 1'b0;
        flag_clr_mask = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pin_in = '1; polarity = '0; irq_en = '1;
        flag_clr_we = 1'b0; flag_clr_mask = '0; stop_mode = 1'b0; lp_strobe = 1'b0;
        step(3);
        check("R1 flags", flag_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 lp req", lp_clk_req_o, 8'hff);
        rst_n = 1'b1;
        irq_en = '0;
        step(10);
    endtask

    task automatic t_fall();
        pin_in[0] = 1'b0;
        step(5);
        check("R2 early", flag_o[0], 0);
        step(1);
        check("R2 set", flag_o[0], 1);
    endtask

    task automatic t_irq();
        #1 check("R8 disabled", irq_o, 0);
        irq_en[0] = 1'b1;
        #1 check("R8 enabled", irq_o, 1);
        irq_en[0] = 1'b0;
        irq_en[3] = 1'b1;
        #1 check("R8 other pin", irq_o, 0);
        irq_en[3] = 1'b0;
    endtask

    task automatic t_w1c();
        flag_clr_we = 1'b1; flag_clr_mask = 8'h02;
        step(1);
        flag_clr_we = 1'b0; flag_clr_mask = '0;
        check("R7 zero bit kept", flag_o[0], 1);
        clear_flags(8'h01);
        check("R7 cleared", flag_o[0], 0);
    endtask

    task automatic t_fresh();
        step(12);
        check("R6 no refire", flag_o[0], 0);
        pin_in[0] = 1'b1;
        step(10);
        pin_in[0] = 1'b0;
        step(6);
        check("R6 after fresh run", flag_o[0], 1);
        clear_flags(8'h01);
    endtask

    task automatic t_rise();
        polarity[1] = 1'b1;
        pin_in[1]   = 1'b0;
        step(12);
        pin_in[1] = 1'b1;
        step(5);
        check("R3 early", flag_o[1], 0);
        step(1);
        check("R3 set", flag_o[1], 1);
        clear_flags(8'h02);
    endtask

    task automatic t_short_active();
        pin_in[2] = 1'b0;
        step(3);
        pin_in[2] = 1'b1;
        step(10);
        check("R4 short active", flag_o[2], 0);
        pin_in[2] = 1'b0;
        step(5);
        check("R4 armed early", flag_o[2], 0);
        step(1);
        check("R4 armed set", flag_o[2], 1);
        clear_flags(8'h04);
    endtask

    task automatic t_short_passive();
        pin_in[3] = 1'b0;
        step(6);
        check("R5 setup edge", flag_o[3], 1);
        clear_flags(8'h08);
        step(5);
        pin_in[3] = 1'b1;
        step(3);
        pin_in[3] = 1'b0;
        step(12);
        check("R5 short passive", flag_o[3], 0);
    endtask

    task automatic t_lp_req();
        irq_en[4] = 1'b1;
        #1 check("R10 armed req", lp_clk_req_o[4], 1);
        check("R10 run", lp_clk_run_o, 1);
        pin_in[4] = 1'b0;
        step(2);
        check("R10 before sample", lp_clk_req_o[4], 1);
        step(1);
        check("R10 active run req", lp_clk_req_o[4], 0);
        check("R10 run off", lp_clk_run_o, 0);
        step(3);
        check("R10 flag set", flag_o[4], 1);
        check("R10 flagged req", lp_clk_req_o[4], 0);
        clear_flags(8'h10);
        check("R10 req after clear", lp_clk_req_o[4], 1);
        irq_en[4] = 1'b0;
        #1 check("R10 disabled req", lp_clk_req_o[4], 0);
    endtask

    task automatic t_stop();
        stop_mode = 1'b1;
        pin_in[5] = 1'b0;
        step(20);
        check("R9 no strobe", flag_o[5], 0);
        for (int k = 0; k < 3; k++) begin
            lp_strobe = 1'b1; step(1);
            lp_strobe = 1'b0; step(2);
        end
        check("R9 three strobes", flag_o[5], 0);
        lp_strobe = 1'b1; step(1);
        lp_strobe = 1'b0;
        check("R9 fourth strobe", flag_o[5], 1);
        stop_mode = 1'b0;
        clear_flags(8'h20);
    endtask

    initial begin
        t_reset();
        t_fall();
        t_irq();
        t_w1c();
        t_fresh();
        t_rise();
        t_short_active();
        t_short_passive();
        t_lp_req();
        t_stop();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule